// File: doc/BRIEF.md
# Three-Input Audio Mix and Routing Engine

This block is a digital datapath that mixes three signed sample streams: a mono phone source and a stereo left/right pair. Each source has its own 5-bit volume code, which selects a gain from a non-uniform decibel law. A 3-bit routing code then builds three outputs from the scaled sources: a bridged speaker output and separate right and left headphone outputs. Each output is a gain-weighted sum, a mute, or a shutdown. The speaker path runs 6 dB hotter than the headphone paths, which is a factor of two in amplitude. Every sum saturates to the sample range instead of wrapping.

Samples enter and leave on a valid/ready stream. An input beat moves when `in_valid` and `in_ready` are both high. The output beat is held steady while `out_valid` is high and `out_ready` is low. During that stall `in_ready` stays low, so the whole two-stage pipeline freezes and no sample is lost or duplicated. `in_ready` equals `!out_valid || out_ready`, so it depends combinationally on `out_ready`. The routing code and the volume codes are plain control pins. The block reads them in the same clock edge that accepts a sample, and that sample carries those settings through the pipeline.

Top module: `audio_mix_router`

## Requirements
- R1: After reset, `out_valid` is 0, all three active flags are 0, all three output samples are 0, and `in_ready` is 1.
- R2: Volume code c selects the headphone gain round(4096·10^(dB/20)) in unsigned Q4.12. For codes 0 to 9 the dB values are −54, −46.5, −40.5, −34.5, −30, −27, −24, −21, −18 and −15. For codes 10 to 31 the value is −13.5 + 1.5·(c−10). So code 19 gives 4096 (unity), code 0 gives 8, and code 31 gives 32536.
- R3: A headphone output is floor(Σ sample·gain / 4096). The speaker output is floor(Σ sample·gain / 2048), which is twice the headphone amplitude.
- R4: The routing code (mode) selects what each output carries. Terms are written Sp = speaker, Hr = right headphone and Hl = left headphone; P, L and R stand for the scaled phone, left and right inputs.
  - 0: all three outputs are in shutdown.
  - 1: Sp = P, and both headphones are muted.
  - 2: Sp is in shutdown, and Hr = Hl = P.
  - 3: Sp = L+R, and both headphones are muted.
  - 4: Sp is in shutdown, Hr = R and Hl = L.
  - 5: Sp = L+R+P, and both headphones are muted.
  - 6: Sp is in shutdown, Hr = R+P and Hl = L+P.
  - 7: Sp = L+R, Hr = R and Hl = L.
- R5: A muted output gives 0 with its active flag at 1, and `out_valid` still rises.
- R6: An output in shutdown gives 0 with its active flag at 0. Mode 0 drives all three flags to 0.
- R7: Every output saturates to the range [−32768, 32767] instead of wrapping.
- R8: The three volume codes act independently. Each scales only its own input.
- R9: A sample accepted at clock edge k appears with `out_valid` high after edge k+1, provided there is no stall. `out_valid` is still low after edge k.
- R10: While `out_valid` is high and `out_ready` is low, all outputs and flags stay unchanged and `in_ready` is 0.
- R11: The mode and the volume codes are sampled at the edge that accepts a sample. Changes after that edge do not alter the sample already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Routing code |
| vol_phone | input | 5 | Phone input volume code |
| vol_left | input | 5 | Left input volume code |
| vol_right | input | 5 | Right input volume code |
| in_valid | input | 1 | Input sample beat valid |
| in_ready | output | 1 | Block can accept an input beat |
| in_phone | input | 16 | Signed phone sample |
| in_left | input | 16 | Signed left sample |
| in_right | input | 16 | Signed right sample |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_spk | output | 16 | Signed speaker sample |
| out_hpr | output | 16 | Signed right headphone sample |
| out_hpl | output | 16 | Signed left headphone sample |
| spk_active | output | 1 | Speaker path not in shutdown |
| hpr_active | output | 1 | Right headphone path not in shutdown |
| hpl_active | output | 1 | Left headphone path not in shutdown |

## Verification
Two events can land in the same cycle: a change of the mode or volume pins, and an output stall. The bench holds a finished beat under back-pressure and, while it is held, switches the routing code and a volume code and offers the next sample. It then checks that the held beat and its flags stay exactly as they were and that `in_ready` stays low. After it releases `out_ready`, it checks that the next sample carries the new settings. A second scenario changes the mode in the cycle right after a sample is accepted. The bench expects that sample to come out under the earlier mode.

// File: rtl/amr_pkg.sv
package amr_pkg;

  localparam int CH_P = 0;
  localparam int CH_L = 1;
  localparam int CH_R = 2;

  typedef enum logic [2:0] {
    RM_OFF        = 3'd0,
    RM_SPK_PHONE  = 3'd1,
    RM_HP_PHONE   = 3'd2,
    RM_SPK_STEREO = 3'd3,
    RM_HP_STEREO  = 3'd4,
    RM_SPK_ALL    = 3'd5,
    RM_HP_MIX     = 3'd6,
    RM_DUAL       = 3'd7
  } route_mode_e;

  typedef struct packed {
    logic spk_on;
    logic hp_on;
    logic spk_p;
    logic spk_l;
    logic spk_r;
    logic hp_p;
    logic hp_st;
  } route_t;

  function automatic route_t decode_route(input logic [2:0] code);
    route_t r;
    r = '0;
    case (route_mode_e'(code))
      RM_SPK_PHONE:  begin r.spk_on = 1'b1; r.hp_on = 1'b1; r.spk_p = 1'b1; end
      RM_HP_PHONE:   begin r.hp_on = 1'b1; r.hp_p = 1'b1; end
      RM_SPK_STEREO: begin r.spk_on = 1'b1; r.hp_on = 1'b1; r.spk_l = 1'b1; r.spk_r = 1'b1; end
      RM_HP_STEREO:  begin r.hp_on = 1'b1; r.hp_st = 1'b1; end
      RM_SPK_ALL:    begin r.spk_on = 1'b1; r.hp_on = 1'b1; r.spk_l = 1'b1; r.spk_r = 1'b1; r.spk_p = 1'b1; end
      RM_HP_MIX:     begin r.hp_on = 1'b1; r.hp_st = 1'b1; r.hp_p = 1'b1; end
      RM_DUAL:       begin r.spk_on = 1'b1; r.hp_on = 1'b1; r.spk_l = 1'b1; r.spk_r = 1'b1; r.hp_st = 1'b1; end
      default:       r = '0;
    endcase
    return r;
  endfunction

  // Headphone-path gain in unsigned Q4.12, rounded from the dB law.
  function automatic logic [15:0] vol_to_gain(input logic [4:0] code);
    logic [15:0] g;
    case (code)
      5'd0:  g = 16'd8;
      5'd1:  g = 16'd19;
      5'd2:  g = 16'd39;
      5'd3:  g = 16'd77;
      5'd4:  g = 16'd130;
      5'd5:  g = 16'd183;
      5'd6:  g = 16'd258;
      5'd7:  g = 16'd365;
      5'd8:  g = 16'd516;
      5'd9:  g = 16'd728;
      5'd10: g = 16'd866;
      5'd11: g = 16'd1029;
      5'd12: g = 16'd1223;
      5'd13: g = 16'd1453;
      5'd14: g = 16'd1727;
      5'd15: g = 16'd2053;
      5'd16: g = 16'd2440;
      5'd17: g = 16'd2900;
      5'd18: g = 16'd3446;
      5'd19: g = 16'd4096;
      5'd20: g = 16'd4868;
      5'd21: g = 16'd5786;
      5'd22: g = 16'd6876;
      5'd23: g = 16'd8173;
      5'd24: g = 16'd9713;
      5'd25: g = 16'd11544;
      5'd26: g = 16'd13720;
      5'd27: g = 16'd16306;
      5'd28: g = 16'd19380;
      5'd29: g = 16'd23034;
      5'd30: g = 16'd27375;
      default: g = 16'd32536;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/amr_gain_lut.sv
module amr_gain_lut #(
  parameter int VW = 5,
  parameter int GW = 16
) (
  input  logic [VW-1:0] code,
  output logic [GW-1:0] gain
);
  always_comb begin
    gain = GW'(amr_pkg::vol_to_gain(5'(code)));
  end
endmodule

// File: rtl/amr_scale.sv
module amr_scale #(
  parameter int SW  = 16,
  parameter int GW  = 16,
  parameter int VW  = 5,
  parameter int MW  = 3,
  parameter int NCH = 3,
  localparam int PW = SW + GW + 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           adv,
  input  logic                           in_valid,
  input  logic [NCH-1:0][SW-1:0]         smp,
  input  logic [NCH-1:0][VW-1:0]         vol,
  input  logic [MW-1:0]                  mode_in,
  output logic                           s1_vld,
  output logic [MW-1:0]                  s1_mode,
  output logic [NCH-1:0][PW-1:0]         s1_prod
);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [GW-1:0]        gain;
    logic signed [PW-1:0] prod;

    amr_gain_lut #(.VW(VW), .GW(GW)) i_lut (
      .code (vol[i]),
      .gain (gain)
    );

    always_comb begin
      prod = $signed(smp[i]) * $signed({1'b0, gain});
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1_prod[i] <= '0;
      end else if (adv && in_valid) begin
        s1_prod[i] <= prod;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_mode <= '0;
    end else if (adv) begin
      s1_vld <= in_valid;
      if (in_valid) s1_mode <= mode_in;
    end
  end

  // R9: an accepted beat occupies the first stage on the next edge
  assert_accept_fills_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && in_valid) |=> s1_vld);

  // R11: settings captured with a beat do not drift while it waits
  assert_mode_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && !adv) |=> ($stable(s1_mode) && s1_vld));

endmodule

// File: rtl/amr_mix.sv
module amr_mix #(
  parameter int SW   = 16,
  parameter int GW   = 16,
  parameter int MW   = 3,
  parameter int FRAC = 12,
  parameter int NCH  = 3,
  localparam int PW  = SW + GW + 1,
  localparam int AW  = PW + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     s1_vld,
  input  logic [MW-1:0]            s1_mode,
  input  logic [NCH-1:0][PW-1:0]   s1_prod,
  output logic                     out_valid,
  output logic signed [SW-1:0]     out_spk,
  output logic signed [SW-1:0]     out_hpr,
  output logic signed [SW-1:0]     out_hpl,
  output logic                     spk_active,
  output logic                     hpr_active,
  output logic                     hpl_active
);
  import amr_pkg::*;

  localparam logic signed [AW-1:0] MAXV = AW'((64'sd1 <<< (SW - 1)) - 64'sd1);
  localparam logic signed [AW-1:0] MINV = -MAXV - AW'(1);

  function automatic logic signed [SW-1:0] clip(input logic signed [AW-1:0] v);
    if (v > MAXV)      return MAXV[SW-1:0];
    else if (v < MINV) return MINV[SW-1:0];
    else               return $signed(v[SW-1:0]);
  endfunction

  route_t               rt;
  logic signed [AW-1:0] tp, tl, tr;
  logic signed [AW-1:0] spk_sum, hpr_sum, hpl_sum;
  logic signed [AW-1:0] spk_sh, hpr_sh, hpl_sh;

  always_comb begin
    rt = decode_route(3'(s1_mode));
    tp = AW'($signed(s1_prod[CH_P]));
    tl = AW'($signed(s1_prod[CH_L]));
    tr = AW'($signed(s1_prod[CH_R]));
    spk_sum = (rt.spk_p ? tp : '0) + (rt.spk_l ? tl : '0) + (rt.spk_r ? tr : '0);
    hpr_sum = (rt.hp_st ? tr : '0) + (rt.hp_p ? tp : '0);
    hpl_sum = (rt.hp_st ? tl : '0) + (rt.hp_p ? tp : '0);
    spk_sh  = spk_sum >>> (FRAC - 1);
    hpr_sh  = hpr_sum >>> FRAC;
    hpl_sh  = hpl_sum >>> FRAC;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_spk    <= '0;
      out_hpr    <= '0;
      out_hpl    <= '0;
      spk_active <= 1'b0;
      hpr_active <= 1'b0;
      hpl_active <= 1'b0;
    end else if (adv) begin
      out_valid <= s1_vld;
      if (s1_vld) begin
        out_spk    <= rt.spk_on ? clip(spk_sh) : '0;
        out_hpr    <= rt.hp_on  ? clip(hpr_sh) : '0;
        out_hpl    <= rt.hp_on  ? clip(hpl_sh) : '0;
        spk_active <= rt.spk_on;
        hpr_active <= rt.hp_on;
        hpl_active <= rt.hp_on;
      end
    end
  end

  // R9: a first-stage beat reaches the output on the next advancing edge
  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s1_vld) |=> out_valid);

  // R6: mode 0 leaves every path dark
  assert_all_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s1_vld && s1_mode == MW'(0)) |=> (!spk_active && !hpr_active && !hpl_active && out_spk == '0));

  // R6: a speaker path in shutdown never carries signal
  assert_dark_speaker_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !spk_active) |-> (out_spk == '0));

  // R5: speaker-only modes mute both headphones but keep them active
  assert_mute_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s1_vld && (s1_mode == MW'(1) || s1_mode == MW'(3) || s1_mode == MW'(5)))
      |=> (hpr_active && hpl_active && out_hpr == '0 && out_hpl == '0 && out_valid));

endmodule

// File: rtl/audio_mix_router.sv
module audio_mix_router #(
  parameter int SW   = 16,
  parameter int GW   = 16,
  parameter int VW   = 5,
  parameter int MW   = 3,
  parameter int FRAC = 12,
  localparam int NCH = 3,
  localparam int PW  = SW + GW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [MW-1:0]        mode_sel,
  input  logic [VW-1:0]        vol_phone,
  input  logic [VW-1:0]        vol_left,
  input  logic [VW-1:0]        vol_right,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [SW-1:0] in_phone,
  input  logic signed [SW-1:0] in_left,
  input  logic signed [SW-1:0] in_right,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [SW-1:0] out_spk,
  output logic signed [SW-1:0] out_hpr,
  output logic signed [SW-1:0] out_hpl,
  output logic                 spk_active,
  output logic                 hpr_active,
  output logic                 hpl_active
);
  import amr_pkg::*;

  logic                   adv;
  logic [NCH-1:0][SW-1:0] smp;
  logic [NCH-1:0][VW-1:0] vol;
  logic                   s1_vld;
  logic [MW-1:0]          s1_mode;
  logic [NCH-1:0][PW-1:0] s1_prod;

  always_comb begin
    adv       = !out_valid || out_ready;
    in_ready  = adv;
    smp[CH_P] = in_phone;
    smp[CH_L] = in_left;
    smp[CH_R] = in_right;
    vol[CH_P] = vol_phone;
    vol[CH_L] = vol_left;
    vol[CH_R] = vol_right;
  end

  amr_scale #(.SW(SW), .GW(GW), .VW(VW), .MW(MW), .NCH(NCH)) i_scale (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .in_valid (in_valid),
    .smp      (smp),
    .vol      (vol),
    .mode_in  (mode_sel),
    .s1_vld   (s1_vld),
    .s1_mode  (s1_mode),
    .s1_prod  (s1_prod)
  );

  amr_mix #(.SW(SW), .GW(GW), .MW(MW), .FRAC(FRAC), .NCH(NCH)) i_mix (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (adv),
    .s1_vld     (s1_vld),
    .s1_mode    (s1_mode),
    .s1_prod    (s1_prod),
    .out_valid  (out_valid),
    .out_spk    (out_spk),
    .out_hpr    (out_hpr),
    .out_hpl    (out_hpl),
    .spk_active (spk_active),
    .hpr_active (hpr_active),
    .hpl_active (hpl_active)
  );

  // R10: a held beat stays put and nothing new is taken in
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_spk) && $stable(out_hpr)
      && $stable(out_hpl) && $stable(spk_active) && $stable(hpr_active) && $stable(hpl_active)));

  assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/test_audio_mix_router.sv
module test_audio_mix_router;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode_sel = '0;
  logic [4:0] vol_phone = 5'd19, vol_left = 5'd19, vol_right = 5'd19;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic signed [15:0] in_phone = '0, in_left = '0, in_right = '0;
  logic in_ready, out_valid, spk_active, hpr_active, hpl_active;
  logic signed [15:0] out_spk, out_hpr, out_hpl;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  audio_mix_router i_audio_mix_router (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .vol_phone(vol_phone),
    .vol_left(vol_left), .vol_right(vol_right), .in_valid(in_valid), .in_ready(in_ready),
    .in_phone(in_phone), .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
    .out_ready(out_ready), .out_spk(out_spk), .out_hpr(out_hpr), .out_hpl(out_hpl),
    .spk_active(spk_active), .hpr_active(hpr_active), .hpl_active(hpl_active)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint bgain(input int code);
    real db;
    case (code)
      0: db = -54.0;  1: db = -46.5;  2: db = -40.5;  3: db = -34.5;  4: db = -30.0;
      5: db = -27.0;  6: db = -24.0;  7: db = -21.0;  8: db = -18.0;  9: db = -15.0;
      default: db = -13.5 + 1.5 * (code - 10);
    endcase
    return longint'($rtoi(4096.0 * (10.0 ** (db / 20.0)) + 0.5));
  endfunction

  function automatic longint sat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // Expected outputs from the routing table (R3, R4, R5, R6, R7)
  task automatic model(input int m, input int p, input int l, input int r,
                       input int vp, input int vl, input int vr,
                       output longint es, output longint er, output longint el,
                       output bit fs, output bit fh);
    longint tp, tl, tr, ss, sr, sl;
    tp = longint'(p) * bgain(vp);
    tl = longint'(l) * bgain(vl);
    tr = longint'(r) * bgain(vr);
    ss = 0; sr = 0; sl = 0; fs = 0; fh = 0;
    case (m)
      1: begin fs = 1; fh = 1; ss = tp; end
      2: begin fh = 1; sr = tp; sl = tp; end
      3: begin fs = 1; fh = 1; ss = tl + tr; end
      4: begin fh = 1; sr = tr; sl = tl; end
      5: begin fs = 1; fh = 1; ss = tl + tr + tp; end
      6: begin fh = 1; sr = tr + tp; sl = tl + tp; end
      7: begin fs = 1; fh = 1; ss = tl + tr; sr = tr; sl = tl; end
      default: ;
    endcase
    es = sat(ss >>> 11);
    er = sat(sr >>> 12);
    el = sat(sl >>> 12);
  endtask

  task automatic compare(input string tag, input int m, input int p, input int l, input int r,
                         input int vp, input int vl, input int vr);
    longint es, er, el;
    bit fs, fh;
    model(m, p, l, r, vp, vl, vr, es, er, el, fs, fh);
    check({tag, " valid"}, out_valid, 1);
    check({tag, " spk"}, out_spk, es);
    check({tag, " hpr"}, out_hpr, er);
    check({tag, " hpl"}, out_hpl, el);
    check({tag, " spk_active"}, spk_active, fs);
    check({tag, " hpr_active"}, hpr_active, fh);
    check({tag, " hpl_active"}, hpl_active, fh);
  endtask

  task automatic push(input string tag, input int m, input int p, input int l, input int r,
                      input int vp, input int vl, input int vr);
    @(negedge clk);
    mode_sel = 3'(m); vol_phone = 5'(vp); vol_left = 5'(vl); vol_right = 5'(vr);
    in_phone = 16'(p); in_left = 16'(l); in_right = 16'(r);
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R9 not yet valid"}, out_valid, 0);
    @(negedge clk);
    compare(tag, m, p, l, r, vp, vl, vr);
  endtask

  task automatic t_reset;
    check("R1 out_valid", out_valid, 0);
    check("R1 flags", {spk_active, hpr_active, hpl_active}, 0);
    check("R1 samples", (out_spk == 0 && out_hpr == 0 && out_hpl == 0), 1);
    check("R1 in_ready", in_ready, 1);
  endtask

  task automatic t_gain_law;
    check("R2 code19 unity", bgain(19), 4096);
    check("R2 code0", bgain(0), 8);
    check("R2 code31", bgain(31), 32536);
    for (int c = 0; c < 32; c++) push("R2 sweep", 2, 7000, 0, 0, c, 19, 19);
    push("R2 negative", 2, -7001, 0, 0, 3, 19, 19);
  endtask

  task automatic t_speaker_double;
    push("R3 speaker x2", 1, 1000, 0, 0, 19, 19, 19);
    check("R3 spk=2000", out_spk, 2000);
    push("R5 muted hp", 3, 0, 500, -300, 19, 19, 19);
  endtask

  task automatic t_modes;
    for (int m = 0; m < 8; m++) push("R4 mode", m, 1200, -700, 300, 19, 16, 22);
    push("R6 off", 0, 9000, 9000, 9000, 31, 31, 31);
    push("R8 left only vol", 4, 0, 2000, 2000, 19, 9, 27);
    push("R8 phone only vol", 6, 3000, 1000, 1000, 25, 19, 19);
  endtask

  task automatic t_saturate;
    push("R7 spk high", 5, 30000, 30000, 30000, 31, 31, 31);
    check("R7 spk max", out_spk, 32767);
    push("R7 spk low", 5, -30000, -30000, -30000, 31, 31, 31);
    check("R7 spk min", out_spk, -32768);
    push("R7 hp mix", 6, 20000, -32768, 32767, 28, 31, 31);
  endtask

  task automatic t_stall_with_ctrl;
    @(negedge clk);
    mode_sel = 3'd4; vol_phone = 5'd19; vol_left = 5'd19; vol_right = 5'd19;
    in_phone = 0; in_left = 100; in_right = 200; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    compare("R10 held beat", 4, 0, 100, 200, 19, 19, 19);
    mode_sel = 3'd7; vol_right = 5'd22;
    in_left = -300; in_right = 400; in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 in_ready low", in_ready, 0);
      compare("R10 stable under stall", 4, 0, 100, 200, 19, 19, 19);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 drained", out_valid, 0);
    @(negedge clk);
    compare("R11 new settings", 7, 0, -300, 400, 19, 19, 22);
  endtask

  task automatic t_ctrl_after_accept;
    @(negedge clk);
    mode_sel = 3'd4; vol_left = 5'd19; vol_right = 5'd19;
    in_left = 1500; in_right = -1500; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; mode_sel = 3'd0; vol_left = 5'd0;
    @(negedge clk);
    compare("R11 in flight", 4, 0, 1500, -1500, 19, 19, 19);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gain_law();
    t_speaker_double();
    t_modes();
    t_saturate();
    t_stall_with_ctrl();
    t_ctrl_after_accept();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule